// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers every interrupt cause of a multi-stream audio controller and drives one level-sensitive interrupt line. It holds the following state:

- a status and control bit pair for each of the two response-ring causes;
- the codec state-change flags and their wake-enable bits;
- three cause bits and three matching enable bits for each stream;
- the interrupt control word.

From these registers it computes a 32-bit summary status word in every cycle. Hardware raises cause bits with single-cycle event pulses. Software reads and writes all of the state through a plain word-addressed register port. Software clears a status bit by writing a one to it.

The summary word sets bit 30 for controller causes and bit `s` for stream `s`. It sets bit 31 whenever any other summary bit is set, whatever the enables are. The line is asserted when both of these hold:

- the global enable (bit 31 of the control word) is on;
- a summary bit is set whose enable is also set in the control word (bit 30 for the controller, bits 7:0 for the streams).

A stored level flag drives the line. The flag changes only on a real transition, one cycle after the status or enable change that causes it.

Top module: `audio_irq_agg`

Register map (word addresses):

| Address | Contents |
|---|---|
| 0 | Interrupt control |
| 1 | Summary status (read-only) |
| 2 | Ring control: bit 0 response enable, bit 1 overrun enable |
| 3 | Ring status (write-1-to-clear): bit 0 response, bit 1 overrun |
| 4 | Wake enable |
| 5 | Codec state-change status (write-1-to-clear) |
| 8+s | Stream `s`: bits 2:0 enables, bits 10:8 causes (write-1-to-clear) |

In each stream's enable and cause fields, bit 0 is completion, bit 1 is FIFO error and bit 2 is descriptor error.

## Requirements
- R1: After reset, the control word reads 0xC00000FF, the summary and every status register read 0, and the line is low.
- R2: Only the control-word bits in mask 0xC00000FF are writable; the other bits always read 0.
- R3: Writing 1 to a bit of the ring, codec or stream status clears that bit; writing 0 leaves it unchanged.
- R4: If a set event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Summary bit 30 is set when ring status AND ring control is nonzero in bit 0 or bit 1.
- R6: Summary bit 30 is set when any codec state-change flag is set, with or without its wake-enable bit.
- R7: Summary bit `s` is set when stream `s` cause bits AND its enable bits are nonzero. A cause whose enable is off is still stored but does not set the summary bit.
- R8: Summary bit 31 is set whenever any of bits 30:0 is set, whatever the control word holds.
- R9: The line goes high one cycle after both conditions hold: global enable bit 31 is on, and the summary AND the control word is nonzero in bit 30 or bits 7:0. It goes low one cycle after either condition stops holding.
- R10: Writes to the summary address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for the write and for the next read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| ring_evt | input | 2 | Ring event pulses: bit 0 response, bit 1 overrun |
| codec_evt | input | NCODEC | Codec state-change pulses |
| strm_evt | input | NSTRM*3 | Stream cause pulses; stream s cause c is at bit s*3+c |
| irq | output | 1 | Level-sensitive interrupt line |

## Verification
A status bit left set or lost inside the block shows within one cycle, as a summary word that disagrees with the stored causes on the next read. A wrong level flag shows as a line that no longer tracks global enable and enabled summary bits one cycle after each write or event. The bench therefore reads the summary and samples the line right after each stimulus. It also checks each cause with its enable off, so a stray enable path shows up as an unexpected line or summary bit.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned GIE_BIT = 31;
  localparam int unsigned CIE_BIT = 30;
  localparam logic [DW-1:0] CTL_MASK = 32'hC000_00FF;
  localparam logic [DW-1:0] CTL_RST  = 32'hC000_00FF;
  localparam int unsigned A_CTL   = 0;
  localparam int unsigned A_SUM   = 1;
  localparam int unsigned A_RCTL  = 2;
  localparam int unsigned A_RSTS  = 3;
  localparam int unsigned A_WAKE  = 4;
  localparam int unsigned A_CSTS  = 5;
  localparam int unsigned A_STRM0 = 8;
  localparam int unsigned NCAUSE  = 3;
  localparam int unsigned STS_LSB = 8;
endpackage

// File: rtl/irq_rw_reg.sv
module irq_rw_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST & MASK;
    else if (wr) q <= wdata & MASK;
  end
endmodule

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (rst) sts_o <= '0;
    else     sts_o <= (sts_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSTRM  = 8,
  parameter int unsigned NCODEC = 4
) (
  input  logic [1:0]                    ring_sts,
  input  logic [1:0]                    ring_ctl,
  input  logic [NCODEC-1:0]             cod_sts,
  input  logic [NCODEC-1:0]             wake_en,
  input  logic [NSTRM-1:0][NCAUSE-1:0]  s_sts,
  input  logic [NSTRM-1:0][NCAUSE-1:0]  s_ctl,
  output logic [DW-1:0]                 sum
);
  logic [NSTRM-1:0] strm_hit;
  logic             ctl_hit;

  for (genvar s = 0; s < NSTRM; s++) begin : g_strm
    assign strm_hit[s] = |(s_sts[s] & s_ctl[s]);
  end

  assign ctl_hit = (|(ring_sts & ring_ctl)) | (|cod_sts) | (|(cod_sts & wake_en));

  always_comb begin
    sum = '0;
    sum[NSTRM-1:0] = strm_hit;
    sum[CIE_BIT]   = ctl_hit;
    sum[GIE_BIT]   = ctl_hit | (|strm_hit);
  end
endmodule

// File: rtl/irq_line.sv
module irq_line
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSTRM = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sum,
  input  logic [DW-1:0] ctl,
  output logic          level
);
  localparam logic [DW-1:0] EN_MASK = (DW'(1) << CIE_BIT) | ((DW'(1) << NSTRM) - DW'(1));
  logic want;

  assign want = ctl[GIE_BIT] & (|(sum & ctl & EN_MASK));

  // The flag moves only on a real transition.
  always_ff @(posedge clk) begin
    if (rst)                 level <= 1'b0;
    else if (want && !level) level <= 1'b1;
    else if (!want && level) level <= 1'b0;
  end
endmodule

// File: rtl/audio_irq_agg.sv
module audio_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSTRM  = 8,
  parameter int unsigned NCODEC = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [1:0]              ring_evt,
  input  logic [NCODEC-1:0]       codec_evt,
  input  logic [NSTRM*NCAUSE-1:0] strm_evt,
  output logic                    irq
);
  localparam int unsigned SW = NSTRM * NCAUSE;

  logic [DW-1:0]                   ictl;
  logic [DW-1:0]                   sum;
  logic [1:0]                      rctl, rsts;
  logic [NCODEC-1:0]               wake, csts;
  logic [NSTRM-1:0][NCAUSE-1:0]    sctl, ssts;
  logic [SW-1:0]                   ssts_flat;
  logic                            unused_wd;

  assign unused_wd = ^reg_wdata;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned t);
    return reg_wr && (int'(a) == int'(t));
  endfunction

  irq_rw_reg #(.W(DW), .MASK(CTL_MASK), .RST(CTL_RST)) u_ctl (
    .clk(clk), .rst(rst), .wr(hit(reg_addr, A_CTL)), .wdata(reg_wdata), .q(ictl));

  irq_rw_reg #(.W(2)) u_rctl (
    .clk(clk), .rst(rst), .wr(hit(reg_addr, A_RCTL)), .wdata(reg_wdata[1:0]), .q(rctl));

  irq_w1c_bank #(.W(2)) u_rsts (
    .clk(clk), .rst(rst), .set_i(ring_evt),
    .clr_i(hit(reg_addr, A_RSTS) ? reg_wdata[1:0] : 2'b00), .sts_o(rsts));

  irq_rw_reg #(.W(NCODEC)) u_wake (
    .clk(clk), .rst(rst), .wr(hit(reg_addr, A_WAKE)), .wdata(reg_wdata[NCODEC-1:0]), .q(wake));

  irq_w1c_bank #(.W(NCODEC)) u_csts (
    .clk(clk), .rst(rst), .set_i(codec_evt),
    .clr_i(hit(reg_addr, A_CSTS) ? reg_wdata[NCODEC-1:0] : '0), .sts_o(csts));

  for (genvar s = 0; s < NSTRM; s++) begin : g_strm
    logic sel;
    assign sel = hit(reg_addr, A_STRM0 + s);
    irq_rw_reg #(.W(NCAUSE)) u_sctl (
      .clk(clk), .rst(rst), .wr(sel), .wdata(reg_wdata[NCAUSE-1:0]), .q(sctl[s]));
    irq_w1c_bank #(.W(NCAUSE)) u_ssts (
      .clk(clk), .rst(rst), .set_i(strm_evt[s*NCAUSE +: NCAUSE]),
      .clr_i(sel ? reg_wdata[STS_LSB +: NCAUSE] : '0), .sts_o(ssts[s]));
  end

  assign ssts_flat = ssts;

  irq_summary #(.NSTRM(NSTRM), .NCODEC(NCODEC)) u_sum (
    .ring_sts(rsts), .ring_ctl(rctl), .cod_sts(csts), .wake_en(wake),
    .s_sts(ssts), .s_ctl(sctl), .sum(sum));

  irq_line #(.NSTRM(NSTRM)) u_line (
    .clk(clk), .rst(rst), .sum(sum), .ctl(ictl), .level(irq));

  logic [DW-1:0] rd_nxt;
  always_comb begin
    rd_nxt = '0;
    case (int'(reg_addr))
      A_CTL:  rd_nxt = ictl;
      A_SUM:  rd_nxt = sum;
      A_RCTL: rd_nxt[1:0] = rctl;
      A_RSTS: rd_nxt[1:0] = rsts;
      A_WAKE: rd_nxt[NCODEC-1:0] = wake;
      A_CSTS: rd_nxt[NCODEC-1:0] = csts;
      default: begin
        for (int s = 0; s < NSTRM; s++) begin
          if (int'(reg_addr) == A_STRM0 + s) begin
            rd_nxt[NCAUSE-1:0]             = sctl[s];
            rd_nxt[STS_LSB +: NCAUSE]      = ssts[s];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end
endmodule

// File: rtl/audio_irq_agg_chk.sv
module audio_irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSTRM  = 8,
  parameter int unsigned NCODEC = 4,
  parameter int unsigned ADDR_W = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    irq,
  input logic [DW-1:0]           ictl,
  input logic [DW-1:0]           sum,
  input logic [1:0]              rsts,
  input logic [1:0]              ring_evt,
  input logic [NSTRM*NCAUSE-1:0] strm_evt,
  input logic [NSTRM*NCAUSE-1:0] ssts_flat,
  input logic                    reg_wr,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [31:0]             reg_wdata
);
  localparam logic [DW-1:0] EN_MASK = (DW'(1) << CIE_BIT) | ((DW'(1) << NSTRM) - DW'(1));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(ictl[GIE_BIT] && (|(sum & ictl & EN_MASK))));

  // R9
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ictl[GIE_BIT]));

  // R2
  ctl_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ictl & ~CTL_MASK) == '0);

  // R3
  ring_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && int'(reg_addr) == A_RSTS && reg_wdata[0] && !ring_evt[0]) |=> !rsts[0]);

  // R4
  for (genvar i = 0; i < NSTRM*NCAUSE; i++) begin : g_set
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      strm_evt[i] |=> ssts_flat[i]);
  end
endmodule

bind audio_irq_agg audio_irq_agg_chk #(.NSTRM(NSTRM), .NCODEC(NCODEC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .ictl(ictl), .sum(sum), .rsts(rsts),
  .ring_evt(ring_evt), .strm_evt(strm_evt), .ssts_flat(ssts_flat),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata));

// File: tb/audio_irq_agg_bench.sv
module audio_irq_agg_bench;
  localparam int NSTRM = 8, NCODEC = 4, ADDR_W = 5;

  logic clk = 0, rst = 1;
  logic reg_wr = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0] ring_evt = '0;
  logic [NCODEC-1:0] codec_evt = '0;
  logic [NSTRM*3-1:0] strm_evt = '0;
  logic irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  audio_irq_agg #(.NSTRM(NSTRM), .NCODEC(NCODEC), .ADDR_W(ADDR_W)) u_audio_irq_agg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ring_evt(ring_evt), .codec_evt(codec_evt),
    .strm_evt(strm_evt), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  // Returns one unit after the edge that loads reg_rdata; irq has updated on that same edge.
  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = ADDR_W'(a);
    @(posedge clk); #1 d = reg_rdata;
  endtask

  task automatic pulse_strm(input int idx);
    @(negedge clk); strm_evt[idx] = 1;
    @(negedge clk); strm_evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); chk("R1 ctl", d, 32'hC00000FF);
    rd(1, d); chk("R1 sum", d, 0);
    rd(3, d); chk("R1 ring sts", d, 0);
    rd(8, d); chk("R1 strm0", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_ctl_mask;
    logic [31:0] d;
    wr(0, 32'hFFFFFFFF); rd(0, d); chk("R2 ones", d, 32'hC00000FF);
    wr(0, 32'h3FFFFF00); rd(0, d); chk("R2 nonwritable", d, 0);
  endtask

  task automatic t_ring;
    logic [31:0] d;
    wr(0, 32'hC0000000); wr(2, 32'h1);
    @(negedge clk); ring_evt = 2'b01; @(negedge clk); ring_evt = 0;
    rd(1, d); chk("R5 sum", d, 32'hC0000000);
    chk("R9 irq ring", {31'd0, irq}, 1);
    wr(3, 32'h0); rd(3, d); chk("R3 write0 keeps", d, 32'h1);
    wr(3, 32'h1); rd(1, d); chk("R3 clear sum", d, 0);
    chk("R9 irq drop", {31'd0, irq}, 0);
    @(negedge clk); ring_evt = 2'b10; @(negedge clk); ring_evt = 0;
    rd(1, d); chk("R5 overrun disabled", d, 0);
    wr(2, 32'h2); rd(1, d); chk("R5 overrun enabled", d, 32'hC0000000);
    wr(3, 32'h3); wr(2, 32'h0);
  endtask

  task automatic t_codec;
    logic [31:0] d;
    @(negedge clk); codec_evt = 4'b0100; @(negedge clk); codec_evt = 0;
    rd(1, d); chk("R6 no wake", d, 32'hC0000000);
    wr(4, 32'h4); rd(1, d); chk("R6 wake", d, 32'hC0000000);
    wr(5, 32'h4); rd(1, d); chk("R6 cleared", d, 0);
    chk("R9 irq codec clear", {31'd0, irq}, 0);
    wr(4, 32'h0);
  endtask

  task automatic t_stream;
    logic [31:0] d;
    wr(0, 32'h80000008); wr(8+3, 32'h2);
    pulse_strm(3*3+1);
    rd(1, d); chk("R7 strm3", d, 32'h80000008);
    chk("R9 irq strm", {31'd0, irq}, 1);
    pulse_strm(5*3+0);
    rd(1, d); chk("R7 strm5 masked", d, 32'h80000008);
    rd(8+5, d); chk("R7 strm5 stored", d, 32'h00000100);
    wr(0, 32'h80000000); rd(1, d); chk("R8 gis", d, 32'h80000008);
    chk("R9 no stream enable", {31'd0, irq}, 0);
    wr(0, 32'h00000008); rd(1, d); chk("R8 gis no gie", d, 32'h80000008);
    chk("R9 no gie", {31'd0, irq}, 0);
    wr(1, 32'hFFFFFFFF); rd(1, d); chk("R10 sum ro", d, 32'h80000008);
    wr(8+3, 32'h00000202); rd(8+3, d); chk("R3 strm clear", d, 32'h2);
    wr(8+5, 32'h00000100); rd(1, d); chk("R3 all clear", d, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    wr(8+0, 32'h1); pulse_strm(0);
    @(negedge clk); reg_wr = 1; reg_addr = ADDR_W'(8); reg_wdata = 32'h101; strm_evt[0] = 1;
    @(negedge clk); reg_wr = 0; reg_wdata = 0; strm_evt = 0;
    rd(8, d); chk("R4 set wins", d, 32'h101);
    wr(8, 32'h100); rd(8, d); chk("R4 then cleared", d, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset; t_ctl_mask; t_ring; t_codec; t_stream; t_set_wins;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule